// File: doc/BRIEF.md
# Multifunction Integer ALU with Barrel Shifter

This block is the combinational execute unit of a small load/store processor core. It takes two operands, a constant shift count and a set of control fields. It returns one result word, a zero flag and a signed-overflow flag. Four sub-units work in parallel: a barrel shifter, a set-on-less-than stage, an adder/subtractor and a bitwise logic unit. A two-bit class field picks which of them drives the result.

The adder is shared. It serves add and subtract directly, and it also supplies the difference that the less-than compare reads. The shifter always moves operand y. The count comes either from the constant input or from the low bits of operand x, which covers both immediate and register shift forms. A load-upper-immediate is done by shifting the immediate left by a constant half the word width.

Top module: `alu_mf`

## Requirements
- R1: `ctl_class` selects the result source: 00 shifter, 01 set-less-than, 10 adder, 11 logic unit.
- R2: In class 10 the result is x+y modulo 2^WIDTH when `ctl_sub` is 0, and x−y modulo 2^WIDTH when `ctl_sub` is 1.
- R3: `ovfl_flag` is 1 only in class 10 and only when the signed two's-complement add or subtract overflows. It is 0 in every other class.
- R4: In class 01 the result is 1 when x is less than y as signed numbers, and 0 otherwise, with all upper bits 0. This holds even when x−y overflows, and `ctl_sub` has no effect.
- R5: In class 11, `ctl_logic_fn` 00 gives x AND y, 01 gives x OR y, 10 gives x XOR y and 11 gives NOR of x and y.
- R6: In class 00, `ctl_shift_fn` 00 passes y unchanged, 01 shifts y left, 10 shifts y right filling with zeros, and 11 shifts y right filling with the original top bit of y.
- R7: The shift count is `const_amt` when `ctl_use_var` is 0, and the low log2(WIDTH) bits of x when it is 1. The higher bits of x do not affect a shift.
- R8: `zero_flag` is 1 exactly when every result bit is 0, in every class.
- R9: A left shift of y by the constant WIDTH/2 places the low half of y in the upper half of the result and zeros in the lower half (load-upper-immediate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | WIDTH | First operand; low bits give the variable shift count |
| opnd_y | input | WIDTH | Second operand; the value that is shifted |
| const_amt | input | log2(WIDTH) | Constant shift count |
| ctl_class | input | 2 | Function class select |
| ctl_shift_fn | input | 2 | Shift kind |
| ctl_use_var | input | 1 | 1 = shift count from opnd_x |
| ctl_sub | input | 1 | 1 = subtract in the adder class |
| ctl_logic_fn | input | 2 | Logic operation select |
| result | output | WIDTH | Selected result |
| zero_flag | output | 1 | Result is all zeros |
| ovfl_flag | output | 1 | Signed overflow in the adder class |

## Verification
The hardest case to reach is a less-than compare where x−y overflows. There the raw sign of the difference gives the wrong answer. The stimulus reaches it by crossing operands at the extremes of the signed range (the most negative value, the most positive value, and their neighbours) with small and mixed-sign values. For variable shifts, x values are chosen with non-zero upper bits, so the stimulus shows that only the low count bits reach the shifter.

// File: rtl/alu_mf_pkg.sv
package alu_mf_pkg;
   typedef enum logic [1:0] {
      CLS_SHIFT = 2'b00,
      CLS_SLT   = 2'b01,
      CLS_ARITH = 2'b10,
      CLS_LOGIC = 2'b11
   } alu_class_e;

   typedef enum logic [1:0] {
      SHF_NONE = 2'b00,
      SHF_SLL  = 2'b01,
      SHF_SRL  = 2'b10,
      SHF_SRA  = 2'b11
   } shift_fn_e;

   typedef enum logic [1:0] {
      LOG_AND = 2'b00,
      LOG_OR  = 2'b01,
      LOG_XOR = 2'b10,
      LOG_NOR = 2'b11
   } logic_fn_e;
endpackage

// File: rtl/alu_mf_adder.sv
module alu_mf_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   wide;

   always_comb begin
      b_eff = b_in ^ {WIDTH{sub}};
      wide  = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
      sum   = wide[MSB:0];
      ovf   = (a_in[MSB] == b_eff[MSB]) && (wide[MSB] != a_in[MSB]);
   end
endmodule

// File: rtl/alu_mf_shifter.sv
module alu_mf_shifter
   import alu_mf_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  shift_fn_e        fn,
   output logic [WIDTH-1:0] dout
);
   localparam int MSB = WIDTH - 1;

   logic             go_left;
   logic             fill;
   logic [SHW-1:0]   amt_eff;
   logic [WIDTH-1:0] stage [SHW+1];

   always_comb begin
      go_left = (fn == SHF_SLL);
      fill    = (fn == SHF_SRA) ? din[MSB] : 1'b0;
      amt_eff = (fn == SHF_NONE) ? '0 : amt;
   end

   assign stage[0] = din;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [WIDTH-1:0] moved;
      always_comb begin
         if (go_left) moved = {stage[k][MSB-S:0], {S{1'b0}}};
         else         moved = {{S{fill}}, stage[k][MSB:S]};
      end
      assign stage[k+1] = amt_eff[k] ? moved : stage[k];
   end

   assign dout = stage[SHW];
endmodule

// File: rtl/alu_mf_logic.sv
module alu_mf_logic
   import alu_mf_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic_fn_e        fn,
   output logic [WIDTH-1:0] dout
);
   always_comb begin
      unique case (fn)
         LOG_AND: dout = a_in & b_in;
         LOG_OR:  dout = a_in | b_in;
         LOG_XOR: dout = a_in ^ b_in;
         default: dout = ~(a_in | b_in);
      endcase
   end
endmodule

// File: rtl/alu_mf.sv
module alu_mf
   import alu_mf_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] opnd_x,
   input  logic [WIDTH-1:0] opnd_y,
   input  logic [SHW-1:0]   const_amt,
   input  logic [1:0]       ctl_class,
   input  logic [1:0]       ctl_shift_fn,
   input  logic             ctl_use_var,
   input  logic             ctl_sub,
   input  logic [1:0]       ctl_logic_fn,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag,
   output logic             ovfl_flag
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("alu_mf: WIDTH must be a power of two of at least 8");
   end
   if (SHW != $clog2(WIDTH)) begin : g_bad_shw
      $error("alu_mf: SHW must equal log2(WIDTH)");
   end

   alu_class_e       cls;
   logic             add_sub;
   logic [WIDTH-1:0] add_sum;
   logic             add_ovf;
   logic [SHW-1:0]   shamt;
   logic [WIDTH-1:0] shf_out;
   logic [WIDTH-1:0] log_out;
   logic             less;

   assign cls     = alu_class_e'(ctl_class);
   // compare always uses the difference
   assign add_sub = ctl_sub | (cls == CLS_SLT);
   assign shamt   = ctl_use_var ? opnd_x[SHW-1:0] : const_amt;

   alu_mf_adder #(.WIDTH(WIDTH)) u_add (
      .a_in (opnd_x),
      .b_in (opnd_y),
      .sub  (add_sub),
      .sum  (add_sum),
      .ovf  (add_ovf)
   );

   alu_mf_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shf (
      .din  (opnd_y),
      .amt  (shamt),
      .fn   (shift_fn_e'(ctl_shift_fn)),
      .dout (shf_out)
   );

   alu_mf_logic #(.WIDTH(WIDTH)) u_log (
      .a_in (opnd_x),
      .b_in (opnd_y),
      .fn   (logic_fn_e'(ctl_logic_fn)),
      .dout (log_out)
   );

   // sign of difference corrected by overflow
   assign less = add_sum[MSB] ^ add_ovf;

   always_comb begin
      unique case (cls)
         CLS_SHIFT: result = shf_out;
         CLS_SLT:   result = {{(WIDTH-1){1'b0}}, less};
         CLS_ARITH: result = add_sum;
         default:   result = log_out;
      endcase
      zero_flag = ~|result;
      ovfl_flag = (cls == CLS_ARITH) & add_ovf;
   end
endmodule

// File: rtl/alu_mf_chk.sv
module alu_mf_chk #(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] opnd_x,
   input logic [WIDTH-1:0] opnd_y,
   input logic [SHW-1:0]   const_amt,
   input logic [1:0]       ctl_class,
   input logic [1:0]       ctl_shift_fn,
   input logic             ctl_use_var,
   input logic             ctl_sub,
   input logic [1:0]       ctl_logic_fn,
   input logic [WIDTH-1:0] result,
   input logic             zero_flag,
   input logic             ovfl_flag
);
   always_comb begin
      AST_ZERO_MATCH: assert (zero_flag == (result == '0))
         else $error("zero flag disagrees with result"); // R8
      AST_NO_OVERFLOW: assert (ctl_class == 2'b10 || !ovfl_flag)
         else $error("overflow outside adder class"); // R3
      AST_SLT_NARROW: assert (ctl_class != 2'b01 || result[WIDTH-1:1] == '0)
         else $error("compare result wider than one bit"); // R4
      AST_ADD_UNDO: assert (!(ctl_class == 2'b10 && !ctl_sub) || (result - opnd_y) == opnd_x)
         else $error("sum minus y is not x"); // R2
      AST_XOR_UNDO: assert (!(ctl_class == 2'b11 && ctl_logic_fn == 2'b10) || (result ^ opnd_y) == opnd_x)
         else $error("xor result not invertible"); // R5
      AST_PASS_Y: assert (!(ctl_class == 2'b00 && ctl_shift_fn == 2'b00) || result == opnd_y)
         else $error("no-shift does not pass y"); // R6
   end
endmodule

bind alu_mf alu_mf_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
   .opnd_x       (opnd_x),
   .opnd_y       (opnd_y),
   .const_amt    (const_amt),
   .ctl_class    (ctl_class),
   .ctl_shift_fn (ctl_shift_fn),
   .ctl_use_var  (ctl_use_var),
   .ctl_sub      (ctl_sub),
   .ctl_logic_fn (ctl_logic_fn),
   .result       (result),
   .zero_flag    (zero_flag),
   .ovfl_flag    (ovfl_flag)
);

// File: tb/sim_alu_mf.sv
`timescale 1ns/1ps
module sim_alu_mf;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] x, y;
   logic [4:0]   camt;
   logic [1:0]   cls, sfn, lfn;
   logic         usev, sub;
   logic [W-1:0] res;
   logic         zf, of;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   alu_mf u0 (
      .opnd_x(x), .opnd_y(y), .const_amt(camt), .ctl_class(cls),
      .ctl_shift_fn(sfn), .ctl_use_var(usev), .ctl_sub(sub),
      .ctl_logic_fn(lfn), .result(res), .zero_flag(zf), .ovfl_flag(of)
   );

   logic [W-1:0] vals [12];
   initial begin
      vals[0]  = 32'h0000_0000; vals[1]  = 32'h0000_0001;
      vals[2]  = 32'hFFFF_FFFF; vals[3]  = 32'h7FFF_FFFF;
      vals[4]  = 32'h8000_0000; vals[5]  = 32'h8000_0001;
      vals[6]  = 32'h7FFF_FFFE; vals[7]  = 32'h5555_5555;
      vals[8]  = 32'hAAAA_AAAA; vals[9]  = 32'hFFFF_FFE3;
      vals[10] = 32'h1234_8765; vals[11] = 32'h0000_0010;
   end

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (x=%h y=%h cls=%b sfn=%b lfn=%b var=%b sub=%b amt=%0d)",
                  tag, act, exp, x, y, cls, sfn, lfn, usev, sub, camt);
      end
   endtask

   // independent model; fills exp, eo
   task automatic model(output logic [W-1:0] exp, output logic eo, output string tag);
      logic [4:0] a;
      eo = 1'b0;
      a  = usev ? x[4:0] : camt;
      case (cls)
         2'b00: begin
            tag = usev ? "R1 R6 R7" : "R1 R6";
            case (sfn)
               2'b00: exp = y;
               2'b01: exp = y << a;
               2'b10: exp = y >> a;
               default: exp = $unsigned($signed(y) >>> a);
            endcase
         end
         2'b01: begin
            tag = "R1 R4";
            exp = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
         end
         2'b10: begin
            tag = "R1 R2";
            if (sub) begin
               exp = x - y;
               eo  = (x[31] != y[31]) && (exp[31] != x[31]);
            end else begin
               exp = x + y;
               eo  = (x[31] == y[31]) && (exp[31] != x[31]);
            end
         end
         default: begin
            tag = "R1 R5";
            case (lfn)
               2'b00: exp = x & y;
               2'b01: exp = x | y;
               2'b10: exp = x ^ y;
               default: exp = ~(x | y);
            endcase
         end
      endcase
   endtask

   task automatic apply_and_check();
      logic [W-1:0] exp;
      logic eo;
      string tag;
      #1;
      model(exp, eo, tag);
      check(tag, res, exp);
      check("R3", {31'd0, of}, {31'd0, eo});
      check("R8", {31'd0, zf}, {31'd0, (exp == '0)});
      #1;
   endtask

   initial begin : main
      x = '0; y = '0; camt = '0; cls = '0; sfn = '0; lfn = '0; usev = 0; sub = 0;
      @(negedge clk);
      // idle state with all-zero inputs: no-shift of zero
      check("R8 idle", {31'd0, zf}, 32'd1);
      check("R3 idle", {31'd0, of}, 32'd0);
      check("R1 idle", res, 32'd0);

      // operand cross for compare, adder and logic classes
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            x = vals[i]; y = vals[j];
            for (int c = 1; c < 4; c++) begin
               for (int s = 0; s < 2; s++) begin
                  for (int f = 0; f < 4; f++) begin
                     cls = 2'(c); sub = 1'(s); lfn = 2'(f); sfn = 2'(f);
                     apply_and_check();
                  end
               end
            end
         end
      end

      // shifter sweep: every count, both count sources
      cls = 2'b00;
      for (int j = 0; j < 12; j++) begin
         for (int a = 0; a < 32; a++) begin
            for (int f = 0; f < 4; f++) begin
               for (int v = 0; v < 2; v++) begin
                  y = vals[j]; sfn = 2'(f); usev = 1'(v);
                  camt = 5'(a);
                  // variable source: upper bits of x set to junk
                  x = {vals[(j + a) % 12][31:5], 5'(31 - a)};
                  apply_and_check();
               end
            end
         end
      end

      // R7: upper bits of x ignored for a variable shift
      cls = 2'b00; sfn = 2'b01; usev = 1; y = 32'h0000_00FF; camt = 5'd0;
      x = 32'hFFFF_FFE4; #1; check("R7 upper x ignored", res, 32'h0000_0FF0); #1;
      x = 32'h0000_0004; #1; check("R7 low x only", res, 32'h0000_0FF0); #1;

      // R9: load-upper-immediate
      usev = 0; camt = 5'd16; y = 32'h0000_BEEF; x = 32'h1234_5678;
      #1; check("R9 lui", res, 32'hBEEF_0000); #1;
      y = 32'hFFFF_0001;
      #1; check("R9 lui high ignored", res, 32'h0001_0000); #1;

      // R4: overflowing difference, sub control ignored
      cls = 2'b01; x = 32'h8000_0000; y = 32'h0000_0001;
      sub = 0; #1; check("R4 ovf lt", res, 32'd1); #1;
      sub = 1; #1; check("R4 ovf lt sub", res, 32'd1); #1;
      x = 32'h7FFF_FFFF; y = 32'hFFFF_FFFF;
      #1; check("R4 ovf ge", res, 32'd0); #1;

      // R3: explicit overflow points
      cls = 2'b10; sub = 0; x = 32'h7FFF_FFFF; y = 32'h0000_0001;
      #1; check("R3 add ovf", {31'd0, of}, 32'd1); check("R2 add wrap", res, 32'h8000_0000); #1;
      sub = 1; x = 32'h8000_0000; y = 32'h0000_0001;
      #1; check("R3 sub ovf", {31'd0, of}, 32'd1); #1;
      cls = 2'b11; #1; check("R3 logic no ovf", {31'd0, of}, 32'd0); #1;

      done = 1'b1;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
      end
   end

   initial begin : finisher
      wait (done);
      #10;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : wd_finish
      repeat (150001) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule